// File: doc/BRIEF.md
# Word-to-Octet Cell Transmit Serializer

This block converts a stream of 32-bit cell data words into a stream of 8-bit octets on a narrow transmit lane. It runs entirely on one fast clock whose rate is four times the word rate. A load strobe, high for one fast cycle, marks each word boundary. On that cycle the block samples the word, a word-valid flag and a cell-start flag. Each accepted word is then sent as four octets on consecutive fast cycles, most significant octet first.

Inside, each captured word is held as an even-octet group (octets 0 and 2) and an odd-octet group (octets 1 and 3). A two-way mux alternates between the groups on every fast cycle, and its result goes into the lane register. A start-of-cell output marks octet 0 of a word that was loaded with its cell-start flag set. A lane clock indication toggles on every fast cycle, so a receiver can capture one octet on each of its edges.

If no valid word is present at a boundary, or no boundary arrives, the lane sends all-zero idle octets with the start-of-cell output low.

Top module: `octet_cell_serializer`

## Requirements
- R1: An accepted word is sent as four octets on four consecutive fast cycles in the order bits [31:24], [23:16], [15:8], [7:0].
- R2: A word sampled on a rising edge with loadStrobe high puts octet 0 on octetOut from the second rising edge after the load edge. Counting the load edge as the first, the output register updates on edge two.
- R3: Loads every four cycles give an unbroken octet stream: octet 3 of one word is followed directly by octet 0 of the next word.
- R4: socOut is 1 only while octet 0 is on octetOut of a word loaded with both cellStart and wordValid high. It is 0 on every other cycle.
- R5: A load with wordValid low makes octetOut 0 and socOut 0 for the four following octet slots.
- R6: While loadStrobe is low, wordIn, wordValid and cellStart have no effect on any output.
- R7: octetClk is 0 after reset and inverts on every rising edge that is not in reset.
- R8: A synchronous active-high rst drives octetOut, socOut and octetClk to 0 at the next edge and cancels any word in progress.
- R9: If no load follows within four cycles, the lane returns to idle (octetOut 0, socOut 0) once octet 3 has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| loadStrobe | input | 1 | Word boundary marker; inputs below are sampled when high |
| wordValid | input | 1 | wordIn holds a real word at this boundary |
| cellStart | input | 1 | This word begins a cell |
| wordIn | input | 32 | Word to send, octet 0 in bits [31:24] |
| octetOut | output | 8 | Transmit lane octet |
| socOut | output | 1 | High while octet 0 of a cell is on the lane |
| octetClk | output | 1 | Lane clock indication, toggles every fast cycle |

## Verification
Directed patterns come first. A single word with distinct bytes exposes any reordering of the octets or a wrong latency. Back-to-back loads show whether a gap or a duplicated octet appears at word boundaries. A load with no valid word separates idle output from stale data. A gap with no strobe shows whether the lane drains to idle after octet 3. Junk on the data inputs while the strobe is low must not reach the outputs. A constrained-random phase then mixes periodic and missing strobes, valid and invalid words, and cell starts. A mid-run reset checks that a word in progress is cancelled. Every cycle is compared against a reference model in the bench.

// File: rtl/octser_pkg.sv
package octser_pkg;
  localparam int LANE_W_DEF = 8;
  localparam int OCTETS_DEF = 4;
  localparam int PHASE_W    = $clog2(OCTETS_DEF);

  // strobes from the control to the datapath
  typedef struct packed {
    logic               loadWord;
    logic               active;
    logic [PHASE_W-1:0] phase;
  } ctrlStrobes_t;
endpackage

// File: rtl/octser_ctrl.sv
module octser_ctrl
  import octser_pkg::*;
#(
  parameter int OCTETS = OCTETS_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loadStrobe,
  input  logic         wordValid,
  output ctrlStrobes_t strobes,
  output logic         octetClk
);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(OCTETS - 1);

  logic [PHASE_W-1:0] phaseQ;
  logic               activeQ;
  logic               clkQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ  <= '0;
      activeQ <= 1'b0;
    end else if (loadStrobe) begin
      phaseQ  <= '0;
      activeQ <= wordValid;
    end else if (activeQ) begin
      if (phaseQ == LAST_PHASE) begin
        activeQ <= 1'b0;
      end else begin
        phaseQ <= phaseQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clkQ <= 1'b0;
    else     clkQ <= ~clkQ;
  end

  always_comb begin
    strobes.loadWord = loadStrobe;
    strobes.active   = activeQ;
    strobes.phase    = phaseQ;
  end

  assign octetClk = clkQ;
endmodule

// File: rtl/octser_datapath.sv
module octser_datapath
  import octser_pkg::*;
#(
  parameter int LANE_W = LANE_W_DEF,
  parameter int OCTETS = OCTETS_DEF,
  localparam int WORD_W = LANE_W * OCTETS,
  localparam int NPAIR  = OCTETS / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic              wordValid,
  input  logic              cellStart,
  input  logic [WORD_W-1:0] wordIn,
  output logic [LANE_W-1:0] octetOut,
  output logic              socOut
);
  logic [LANE_W-1:0] evenStage [NPAIR];
  logic [LANE_W-1:0] oddStage  [NPAIR];
  logic              stgSoc;

  // octet n lives at bits [WORD_W-1-n*LANE_W -: LANE_W]
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        evenStage[p] <= '0;
        oddStage[p]  <= '0;
      end else if (strobes.loadWord) begin
        evenStage[p] <= wordIn[WORD_W-1-(2*p)*LANE_W   -: LANE_W];
        oddStage[p]  <= wordIn[WORD_W-1-(2*p+1)*LANE_W -: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   stgSoc <= 1'b0;
    else if (strobes.loadWord) stgSoc <= cellStart & wordValid;
  end

  logic [PHASE_W-2:0] pairIdx;
  logic [LANE_W-1:0]  evenPick;
  logic [LANE_W-1:0]  oddPick;
  logic [LANE_W-1:0]  muxOctet;

  always_comb begin
    pairIdx  = strobes.phase[PHASE_W-1:1];
    evenPick = evenStage[pairIdx];
    oddPick  = oddStage[pairIdx];
    muxOctet = strobes.phase[0] ? oddPick : evenPick;
  end

  always_ff @(posedge clk) begin
    if (rst || !strobes.active) begin
      octetOut <= '0;
      socOut   <= 1'b0;
    end else begin
      octetOut <= muxOctet;
      socOut   <= stgSoc && (strobes.phase == '0);
    end
  end
endmodule

// File: rtl/octet_cell_serializer.sv
module octet_cell_serializer
  import octser_pkg::*;
#(
  parameter int LANE_W = LANE_W_DEF,
  parameter int OCTETS = OCTETS_DEF,
  localparam int WORD_W = LANE_W * OCTETS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadStrobe,
  input  logic              wordValid,
  input  logic              cellStart,
  input  logic [WORD_W-1:0] wordIn,
  output logic [LANE_W-1:0] octetOut,
  output logic              socOut,
  output logic              octetClk
);
  ctrlStrobes_t strobes;

  octser_ctrl #(.OCTETS(OCTETS)) u_ctrl (
    .clk(clk), .rst(rst), .loadStrobe(loadStrobe), .wordValid(wordValid),
    .strobes(strobes), .octetClk(octetClk)
  );

  octser_datapath #(.LANE_W(LANE_W), .OCTETS(OCTETS)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wordValid(wordValid),
    .cellStart(cellStart), .wordIn(wordIn), .octetOut(octetOut), .socOut(socOut)
  );
endmodule

// File: rtl/octser_checker.sv
module octser_checker #(
  parameter int LANE_W = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              loadStrobe,
  input logic              wordValid,
  input logic              cellStart,
  input logic [WORD_W-1:0] wordIn,
  input logic [LANE_W-1:0] octetOut,
  input logic              socOut,
  input logic              octetClk
);
  p_reset_clear_r8: assert property (@(posedge clk)
    $past(rst) |-> (octetOut == '0 && !socOut && !octetClk));

  p_clk_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (octetClk != $past(octetClk)));

  p_soc_single_r4: assert property (@(posedge clk) disable iff (rst)
    socOut |=> !socOut);

  p_soc_latency_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(loadStrobe && wordValid && cellStart, 2) && !$past(rst, 2) && !$past(rst))
      |-> socOut);

  p_octet0_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(loadStrobe && wordValid, 2) && !$past(rst, 2) && !$past(rst))
      |-> (octetOut == $past(wordIn[WORD_W-1 -: LANE_W], 2)));

  p_invalid_idle_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(loadStrobe && !wordValid, 2) && !$past(rst, 2) && !$past(rst))
      |-> (octetOut == '0 && !socOut));
endmodule

bind octet_cell_serializer octser_checker #(.LANE_W(LANE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .loadStrobe(loadStrobe), .wordValid(wordValid),
  .cellStart(cellStart), .wordIn(wordIn), .octetOut(octetOut),
  .socOut(socOut), .octetClk(octetClk)
);

// File: tb/tb_octet_cell_serializer.sv
`timescale 1ns/1ps
module tb_octet_cell_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadStrobe = 1'b0;
  logic        wordValid = 1'b0;
  logic        cellStart = 1'b0;
  logic [31:0] wordIn = '0;
  logic [7:0]  octetOut;
  logic        socOut;
  logic        octetClk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  octet_cell_serializer dut (
    .clk(clk), .rst(rst), .loadStrobe(loadStrobe), .wordValid(wordValid),
    .cellStart(cellStart), .wordIn(wordIn), .octetOut(octetOut),
    .socOut(socOut), .octetClk(octetClk)
  );

  // reference model state
  logic [31:0] mWord = '0;
  bit          mValid = 0;
  bit          mSoc = 0;
  int          mCnt = 0;
  logic [7:0]  expOct = '0;
  bit          expSoc = 0;
  bit          expClk = 0;
  string       curTag = "R8";

  function automatic logic [7:0] octetOf(logic [31:0] w, int i);
    return w[31-8*i -: 8];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive inputs for one edge, update model, check after the edge
  task automatic step(bit r, bit ld, bit v, bit cs, logic [31:0] w);
    rst = r; loadStrobe = ld; wordValid = v; cellStart = cs; wordIn = w;
    @(posedge clk);
    if (r) begin
      expOct = '0; expSoc = 0; expClk = 0; mCnt = 0; mValid = 0;
    end else begin
      expClk = !expClk;
      if (mCnt > 0) begin
        expOct = mValid ? octetOf(mWord, 4 - mCnt) : 8'h00;
        expSoc = mValid && mSoc && (mCnt == 4);
        mCnt--;
      end else begin
        expOct = '0; expSoc = 0;
      end
      if (ld) begin
        mWord = w; mValid = v; mSoc = cs; mCnt = 4;
      end
    end
    @(negedge clk);
    check(curTag, {24'h0, octetOut}, {24'h0, expOct});
    check("R4", {31'h0, socOut}, {31'h0, expSoc});
    check("R7", {31'h0, octetClk}, {31'h0, expClk});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog: actual=running expected=finished");
    errors++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R8: reset state
    curTag = "R8";
    step(1, 0, 0, 0, 32'h0);
    step(1, 1, 1, 1, 32'hDEAD_BEEF);

    // R2 and R1: single cell-start word with distinct bytes
    curTag = "R2";
    step(0, 1, 1, 1, 32'hA1B2_C3D4);
    curTag = "R1";
    idle(3);
    // R9: lane drains after octet 3
    curTag = "R9";
    idle(5);

    // R3: back-to-back words
    curTag = "R3";
    step(0, 1, 1, 1, 32'h1122_3344); idle(3);
    step(0, 1, 1, 0, 32'h5566_7788); idle(3);
    step(0, 1, 1, 0, 32'h99AA_BBCC); idle(3);
    step(0, 1, 1, 1, 32'hDDEE_FF01); idle(3);
    idle(2);

    // R5: invalid word at a boundary
    curTag = "R5";
    step(0, 1, 0, 1, 32'hFFFF_FFFF); idle(3);
    idle(2);

    // R6: junk while strobe is low, around a valid word
    curTag = "R6";
    step(0, 1, 1, 0, 32'h0F1E_2D3C);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, $urandom);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, $urandom);

    // R8: reset cancels a word in progress
    curTag = "R8";
    step(0, 1, 1, 1, 32'hCAFE_F00D);
    step(0, 0, 0, 0, 32'h0);
    step(1, 0, 0, 0, 32'h0);
    curTag = "R9";
    idle(4);

    // random phase
    curTag = "R1";
    for (int n = 0; n < 400; n++) begin
      bit gap = ($urandom % 8) == 0;
      bit v   = ($urandom % 5) != 0;
      bit cs  = ($urandom % 3) == 0;
      logic [31:0] w = $urandom;
      step(0, !gap, v, cs, w);
      for (int i = 0; i < 3; i++) step(0, 0, $urandom % 2, $urandom % 2, $urandom);
    end
    idle(6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule